// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block is a register-mapped general-purpose I/O unit for up to 32 pins. Software reaches it through a plain 32-bit port: a write strobe, a read strobe, a byte address and write data. Read data is registered and appears one cycle after the read strobe. Each pin has an output level, a direction bit and an interrupt trigger. The pad buffer lies outside the block and is driven through separate output and output-enable vectors. Pin inputs pass through a two-stage synchroniser before any use.

Each pin's trigger comes from three configuration bits: a mode bit (level or edge), a polarity bit, and an any-edge bit. The any-edge register is built only when the `VERSION` parameter is 3 or more. Detected conditions latch into a raw status vector. This vector is ANDed with an enable mask to give the pending vector. The single interrupt output is the OR of the pending bits. Software acknowledges a pin by writing a 1 to its bit in the clear register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the enable mask, output levels, status bits, `irq`, `rdata` and `pin_oe` are all 0, every direction bit is 1, and every polarity bit is 1.
- R2: Direction is at byte address 0x04. A direction bit of 1 makes the pin an input (`pin_oe` bit low). A 0 makes it an output (`pin_oe` bit high). `pin_out` always shows the value register, and `pin_oe` changes only on a direction write.
- R3: A read of address 0x00 returns the synchronised pin level for input bits and the written output level for output bits. A write to 0x00 sets the output levels. Read data is valid in the cycle after the read strobe.
- R4: With mode bit 0 (address 0x18) a pin triggers on level: high when its polarity bit (address 0x1C) is 1, low when it is 0. A level condition latches status three clock edges after the pin changes.
- R5: With mode bit 1 and the any-edge bit clear, a pin latches status on a rising edge when polarity is 1 and on a falling edge when polarity is 0.
- R6: With mode bit 1 and the any-edge bit (address 0x24) set, both transitions latch status and polarity is ignored. When `VERSION` is below 3 the any-edge register reads 0 and writes to it are ignored.
- R7: Writing 1 to a bit of the clear register (address 0x14) clears that status bit. A 0 bit has no effect. The clear register reads as 0.
- R8: If an edge event and a clear of the same bit happen in the same cycle, the status bit stays set.
- R9: A cleared level-triggered bit reads 0 for one cycle. It is set again on the next cycle if its level condition still holds.
- R10: Status reads at 0x0C without masking. Pending reads at 0x10 as status AND the enable mask (address 0x08). `irq` is the OR of the pending bits, so an all-zero mask holds `irq` low.
- R11: Address 0x20 is read-only and returns `VERSION`. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pad input levels (asynchronous) |
| pin_out | output | NPINS | Levels to drive on output pads |
| pin_oe | output | NPINS | Pad output enables, high drives |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker watches, on every cycle, the properties that depend only on local state:
- a status bit never rises without a trigger hit;
- a clear with no event always drops its bits;
- an edge hit always lands in status;
- the all-zero enable mask holds `irq` low;
- the output enables stay put between direction writes;
- the version and (on older versions) any-edge reads return fixed values.

Only the bench's scenarios can show that each of the five trigger kinds responds to the correct pin transitions with the three-edge latency. The same applies to the same-cycle edge-versus-clear race, the one-cycle dip of a re-asserting level bit, and the mixed input and output readback of the value register. The bench sweeps every pin through every trigger kind. It runs a second instance with a lower version to show the any-edge gating.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int BUS_W        = 32;
    localparam int ADDR_W       = 6;
    localparam int MAX_PINS     = 32;
    localparam int BOTH_MIN_VER = 3;

    // byte addresses of the register file
    typedef enum logic [ADDR_W-1:0] {
        RA_LEVEL  = 6'h00,
        RA_DIR    = 6'h04,
        RA_ENABLE = 6'h08,
        RA_STATUS = 6'h0C,
        RA_PEND   = 6'h10,
        RA_ACK    = 6'h14,
        RA_MODE   = 6'h18,
        RA_POL    = 6'h1C,
        RA_VER    = 6'h20,
        RA_ANYEDG = 6'h24
    } reg_addr_e;

    typedef struct packed {
        logic is_edge;   // 0: level, 1: edge
        logic pol;       // 1: high / rising, 0: low / falling
        logic any_edge;  // both transitions when is_edge is set
    } trig_cfg_t;

    function automatic logic trig_hit(trig_cfg_t c, logic cur, logic prev);
        if (!c.is_edge)
            return c.pol ? cur : ~cur;
        if (c.any_edge)
            return cur ^ prev;
        return c.pol ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                q[i]      <= 1'b0;
            end else begin
                meta_q[i] <= d[i];
                q[i]      <= meta_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_trig.sv
`timescale 1ns/1ps
module gpio_trig
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] mode_v,
    input  logic [NPINS-1:0] pol_v,
    input  logic [NPINS-1:0] any_v,
    output logic [NPINS-1:0] hit
);
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        trig_cfg_t cfg;
        assign cfg    = '{is_edge: mode_v[i], pol: pol_v[i], any_edge: any_v[i]};
        assign hit[i] = trig_hit(cfg, lvl[i], prev_q[i]);
    end
endmodule

// File: rtl/gpio_status.sv
`timescale 1ns/1ps
module gpio_status #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] edge_mask,
    input  logic             ack_we,
    input  logic [NPINS-1:0] ack_bits,
    output logic [NPINS-1:0] status
);
    logic [NPINS-1:0] ack;
    logic [NPINS-1:0] keep;
    logic [NPINS-1:0] set;

    always_comb begin
        ack  = ack_we ? ack_bits : '0;
        keep = status & ~ack;
        // edge hits beat an ack; level hits wait one cycle after an ack
        set  = hit & (edge_mask | ~ack);
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= keep | set;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS   = 32,
    parameter int VERSION = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam bit HAS_ANY = (VERSION >= BOTH_MIN_VER);

    logic [NPINS-1:0] out_q, dir_q, ien_q, mode_q, pol_q, any_q;
    logic [NPINS-1:0] pin_sync, hit, status_q, pend;
    logic [NPINS-1:0] wr_bits;
    logic [BUS_W-1:0] rd_mux;

    assign wr_bits = wdata[NPINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '1;
            ien_q  <= '0;
            mode_q <= '0;
            pol_q  <= '1;
        end else if (wr_en) begin
            case (addr)
                RA_LEVEL:  out_q  <= wr_bits;
                RA_DIR:    dir_q  <= wr_bits;
                RA_ENABLE: ien_q  <= wr_bits;
                RA_MODE:   mode_q <= wr_bits;
                RA_POL:    pol_q  <= wr_bits;
                default: ;
            endcase
        end
    end

    if (HAS_ANY) begin : g_any
        always_ff @(posedge clk) begin
            if (rst)                            any_q <= '0;
            else if (wr_en && addr == RA_ANYEDG) any_q <= wr_bits;
        end
    end else begin : g_no_any
        assign any_q = '0;
    end

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
    );

    gpio_trig #(.NPINS(NPINS)) u_trig (
        .clk(clk), .rst(rst), .lvl(pin_sync),
        .mode_v(mode_q), .pol_v(pol_q), .any_v(any_q), .hit(hit)
    );

    gpio_status #(.NPINS(NPINS)) u_stat (
        .clk(clk), .rst(rst), .hit(hit), .edge_mask(mode_q),
        .ack_we(wr_en && addr == RA_ACK), .ack_bits(wr_bits),
        .status(status_q)
    );

    assign pend    = status_q & ien_q;
    assign irq     = |pend;
    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;

    always_comb begin
        rd_mux = '0;
        case (addr)
            RA_LEVEL:  rd_mux[NPINS-1:0] = (pin_sync & dir_q) | (out_q & ~dir_q);
            RA_DIR:    rd_mux[NPINS-1:0] = dir_q;
            RA_ENABLE: rd_mux[NPINS-1:0] = ien_q;
            RA_STATUS: rd_mux[NPINS-1:0] = status_q;
            RA_PEND:   rd_mux[NPINS-1:0] = pend;
            RA_MODE:   rd_mux[NPINS-1:0] = mode_q;
            RA_POL:    rd_mux[NPINS-1:0] = pol_q;
            RA_ANYEDG: rd_mux[NPINS-1:0] = any_q;
            RA_VER:    rd_mux            = BUS_W'(VERSION);
            default:   rd_mux            = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk #(
    parameter int NPINS   = 8,
    parameter int VERSION = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [5:0]       addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic             irq,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] status_q,
    input logic [NPINS-1:0] ien_q,
    input logic [NPINS-1:0] hit,
    input logic [NPINS-1:0] mode_q
);
    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

    // R7
    ack_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 6'h14) |=>
            ((status_q & $past(wdata[NPINS-1:0]) & ~$past(hit)) == '0));

    // R8
    edge_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|(hit & mode_q)) |=>
            ((status_q & $past(hit & mode_q)) == $past(hit & mode_q)));

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0));

    // R2
    oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 6'h04) |=> $stable(pin_oe));

    // R11
    version_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 6'h20) |=> (rdata == 32'(VERSION)));

    if (VERSION < 3) begin : g_old
        // R6
        anyedge_absent_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_en && addr == 6'h24) |=> (rdata == '0));
    end
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .pin_oe(pin_oe),
    .status_q(status_q), .ien_q(ien_q), .hit(hit), .mode_q(mode_q)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  pin_in = '0;
    logic [31:0] rdata, rdata2;
    logic [7:0]  pin_out, pin_oe, pin_out2, pin_oe2;
    logic        irq, irq2;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(8), .VERSION(3)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    gpio_irq_ctrl #(.NPINS(8), .VERSION(2)) dut_v2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata2), .pin_in(pin_in), .pin_out(pin_out2),
        .pin_oe(pin_oe2), .irq(irq2)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic [31:0] d2);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; d2 = rdata2;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // modes: 0 level-high, 1 level-low, 2 rising, 3 falling, 4 any-edge
    function automatic logic [7:0] exp_stat(int mode, int phase, int p, bit v3);
        logic [7:0] b;
        b = 8'(1 << p);
        if (phase == 2) return (mode == 1) ? 8'hFF : 8'h00;
        if (phase == 3) begin
            case (mode)
                1:       return 8'hFF;
                3:       return 8'h00;
                default: return b;
            endcase
        end
        case (mode)
            0:       return b;
            1:       return 8'hFF;
            2:       return 8'h00;
            3:       return b;
            default: return v3 ? b : 8'h00;
        endcase
    endfunction

    function automatic string mode_tag(int mode);
        if (mode < 2)  return "R4 level";
        if (mode < 4)  return "R5 edge";
        return "R6 any-edge";
    endfunction

    initial begin
        logic [31:0] d, d2;
        logic [7:0]  e;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 pin_out", 32'(pin_out), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 rdata", rdata, 32'h0);
        rd(6'h08, d, d2); check("R1 enable", d, 32'h0);
        rd(6'h04, d, d2); check("R1 direction", d, 32'hFF);
        rd(6'h1C, d, d2); check("R1 polarity", d, 32'hFF);
        rd(6'h0C, d, d2); check("R1 status", d, 32'h0);

        // R2 R3 direction and value readback
        wr(6'h04, 32'h0F);
        wr(6'h00, 32'hA5);
        pin_in = 8'h3C;
        settle();
        check("R2 pin_oe", 32'(pin_oe), 32'hF0);
        check("R2 pin_out", 32'(pin_out), 32'hA5);
        rd(6'h00, d, d2); check("R3 value read", d, 32'hAC);
        wr(6'h04, 32'hFF);
        pin_in = 8'h00;
        settle();
        check("R2 pin_oe inputs", 32'(pin_oe), 32'h00);

        // R11 version
        wr(6'h20, 32'h55);
        rd(6'h20, d, d2);
        check("R11 version", d, 32'd3);
        check("R11 version v2", d2, 32'd2);

        // R6 gating of the any-edge register
        wr(6'h24, 32'hFF);
        rd(6'h24, d, d2);
        check("R6 any-edge reg", d, 32'hFF);
        check("R6 any-edge absent v2", d2, 32'h0);

        // sweep every pin through every trigger kind
        for (int m = 0; m < 5; m++) begin
            for (int p = 0; p < 8; p++) begin
                wr(6'h18, (m >= 2) ? 32'hFF : 32'h0);
                wr(6'h1C, (m == 0 || m == 2 || m == 4) ? 32'hFF : 32'h0);
                wr(6'h24, (m == 4) ? 32'hFF : 32'h0);
                wr(6'h14, 32'hFF);
                rd(6'h0C, d, d2);
                check({mode_tag(m), " R9 after ack"}, d, 32'(exp_stat(m, 2, p, 1'b1)));
                pin_in[p] = 1'b1;
                settle();
                wr(6'h08, 32'(1 << p));
                rd(6'h0C, d, d2);
                e = exp_stat(m, 3, p, 1'b1);
                check({mode_tag(m), " pin up"}, d, 32'(e));
                check({mode_tag(m), " pin up v2"}, d2, 32'(e));
                rd(6'h10, d, d2);
                check("R10 pending", d, 32'(e & 8'(1 << p)));
                check("R10 irq", 32'(irq), 32'(|(e & 8'(1 << p))));
                wr(6'h08, 32'h0);
                wr(6'h14, 32'hFF);
                pin_in[p] = 1'b0;
                settle();
                rd(6'h0C, d, d2);
                check({mode_tag(m), " pin down"}, d, 32'(exp_stat(m, 4, p, 1'b1)));
                check({mode_tag(m), " pin down v2"}, d2, 32'(exp_stat(m, 4, p, 1'b0)));
                check("R10 masked irq", 32'(irq), 32'h0);
            end
        end

        // R7 ack semantics, rising mode on all pins
        wr(6'h18, 32'hFF); wr(6'h1C, 32'hFF); wr(6'h24, 32'h0);
        wr(6'h14, 32'hFF);
        pin_in = 8'h0F;
        settle();
        rd(6'h0C, d, d2); check("R7 setup", d, 32'h0F);
        wr(6'h14, 32'h0);
        rd(6'h0C, d, d2); check("R7 zero write", d, 32'h0F);
        wr(6'h14, 32'h01);
        rd(6'h0C, d, d2); check("R7 single ack", d, 32'h0E);
        rd(6'h14, d, d2); check("R7 ack reads zero", d, 32'h0);

        // R8 edge and ack of the same bit in one cycle
        pin_in[1] = 1'b0;
        settle();
        @(negedge clk); pin_in[1] = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 6'h14; wdata = 32'h06;
        @(negedge clk); wr_en = 1'b0;
        rd(6'h0C, d, d2); check("R8 edge beats ack", d, 32'h0A);

        // R9 level bit dips one cycle after ack
        wr(6'h18, 32'h0);
        wr(6'h1C, 32'hFF);
        settle();
        @(negedge clk); wr_en = 1'b1; addr = 6'h14; wdata = 32'h01;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; addr = 6'h0C;
        @(negedge clk); rd_en = 1'b0;
        check("R9 dip", rdata & 32'h1, 32'h0);
        rd(6'h0C, d, d2); check("R9 reassert", d & 32'h1, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule